// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Engine

The engine watches the output of a demodulating infrared receiver and records the message it carries as a list of durations. The input is sampled once per sampling tick. A prescaler divides the system clock by a programmable period to make that tick. A short de-glitch counter then filters the sampled level. Each accepted mark (active level) and each space (idle level) is timed in ticks. The time is clamped to 8 bits and packed into a bank of 17 readable 32-bit capture words, which hold 68 byte slots.

Capture begins at the first mark after a restart, and the idle line before that mark is not recorded. A message ends in one of two ways. In the first, a space saturates at 255 ticks, and after a programmable settling count the engine declares completion. In the second, all 68 slots fill. Either way a pending interrupt flag is set. The host reads the bank, writes a restart to clear the bank and rearm, and acknowledges the interrupt. Host access goes through a single-cycle register port: one write per enabled clock and a combinational read.

Top module: `ir_pw_capture`

## Requirements
- R1: After reset, every register reads its default value and `irq_o` is 0:
  - word 0x00 (control) reads 0x000F0000;
  - word 0x01 (tick period) reads 4;
  - word 0x02 (filter) reads 0x00000100;
  - word 0x03 (interrupt enable) reads 0;
  - all capture words at 0x10..0x20 read 0.
- R2: The engine makes no ticks and records nothing unless control bit 0 (run) and control bit 13 (width detect) are both 1.
- R3: A duration is counted in sampling ticks. One tick lasts the number of system clocks held in word 0x01 [15:0]; a value of 0 acts as 1.
- R4: Slot s is stored in capture word 0x10 + s/4, at bits [8(s%4)+7 : 8(s%4)]. Slots fill in order, starting at slot 0.
- R5: The input is active low, so `ir_i` = 0 is a mark. Slot 0 always holds the first mark after a restart, and the slots then alternate space, mark, space. The idle line before that first mark is not stored.
- R6: A mark longer than 255 ticks is stored as 0xFF and does not end the message.
- R7: A space that reaches 255 ticks is stored as 0xFF and ends the message. The engine then waits the settling count in control [23:16] plus one more tick, and then sets the pending interrupt flag.
- R8: Once slot 67 is written, capture stops, later edges change no capture word, and the pending interrupt flag is set.
- R9: A level change is accepted only after the number of consecutive differing samples held in word 0x02 [12:8]; a value of 0 acts as 1. A shorter excursion is ignored and merges into the surrounding duration.
- R10: `irq_o` equals the pending flag AND word 0x03 bit 0. Writing 1 to bit 0 of word 0x04 clears the pending flag.
- R11: Writing 1 to bit 0 of word 0x05 sets every capture word to 0 and returns the engine to waiting for a first mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated infrared input, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a full bank. To get there, the input must carry 68 accepted edges before any space saturates. The bench drives 34 short mark/space pairs at a one-clock tick, followed by one extra mark that commits slot 67. It then adds further pulses and checks that no capture word changes. De-glitch behaviour is reached by raising the filter count and inserting a space shorter than that count inside a mark. The bench then checks that the stored durations stay exact, because every accepted edge is delayed by the same number of ticks.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DUR_W  = 8;
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h00;
  localparam logic [ADDR_W-1:0] A_PERIOD  = 6'h01;
  localparam logic [ADDR_W-1:0] A_FILTER  = 6'h02;
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 6'h03;
  localparam logic [ADDR_W-1:0] A_IRQ_ACK = 6'h04;
  localparam logic [ADDR_W-1:0] A_RESTART = 6'h05;
  localparam logic [ADDR_W-1:0] A_BANK    = 6'h10;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_PWD_BIT = 13;

  typedef enum logic [2:0] {
    CAP_IDLE,
    CAP_MARK,
    CAP_SPACE,
    CAP_SETTLE,
    CAP_DONE
  } cap_state_e;
endpackage

// File: rtl/ir_cap_tick.sv
module ir_cap_tick #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] lim;

  assign lim    = (period_i == '0) ? '0 : period_i - PERIOD_W'(1);
  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else                  cnt_q <= cnt_q + PERIOD_W'(1);
  end
endmodule

// File: rtl/ir_cap_deglitch.sv
module ir_cap_deglitch #(
  parameter int unsigned DG_W       = 5,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ir_i,
  input  logic            tick_i,
  input  logic [DG_W-1:0] dg_i,
  output logic            mark_o
);
  localparam logic IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;

  logic [1:0]      sync_q;
  logic            act;
  logic            lvl_q;
  logic [DG_W-1:0] cnt_q;
  logic [DG_W-1:0] cnt_p1;
  logic [DG_W-1:0] dg_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {2{IDLE_LVL}};
    else         sync_q <= {sync_q[0], ir_i};
  end

  if (ACTIVE_LOW) begin : g_low
    assign act = ~sync_q[1];
  end else begin : g_high
    assign act = sync_q[1];
  end

  assign dg_eff = (dg_i == '0) ? DG_W'(1) : dg_i;
  assign cnt_p1 = cnt_q + DG_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (act == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_p1 >= dg_eff) begin
        lvl_q <= act;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_p1;
      end
    end
  end

  assign mark_o = lvl_q;
endmodule

// File: rtl/ir_cap_fsm.sv
module ir_cap_fsm
  import ir_cap_pkg::*;
#(
  parameter int unsigned SLOTS  = 68,
  parameter int unsigned SLOT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mark_i,
  input  logic              restart_i,
  input  logic [DUR_W-1:0]  settle_i,
  output logic              wr_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [DUR_W-1:0]  wr_dur_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              done_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  cap_state_e        state_q, state_d;
  logic [DUR_W-1:0]  dur_q, dur_d, settle_q, settle_d, dur_inc;
  logic [SLOT_W-1:0] slot_q, slot_d;

  assign dur_inc = (dur_q == DUR_MAX) ? DUR_MAX : dur_q + DUR_W'(1);

  always_comb begin
    state_d  = state_q;
    dur_d    = dur_q;
    slot_d   = slot_q;
    settle_d = settle_q;
    wr_o     = 1'b0;
    wr_dur_o = dur_q;
    done_o   = 1'b0;
    if (restart_i) begin
      state_d  = CAP_IDLE;
      dur_d    = '0;
      slot_d   = '0;
      settle_d = '0;
    end else if (tick_i) begin
      unique case (state_q)
        CAP_IDLE: if (mark_i) begin
          state_d = CAP_MARK;
          dur_d   = DUR_W'(1);
        end
        CAP_MARK: begin
          if (mark_i) dur_d = dur_inc;
          else begin
            wr_o   = 1'b1;
            slot_d = slot_q + SLOT_W'(1);
            dur_d  = DUR_W'(1);
            if (slot_q == LAST) begin
              state_d = CAP_DONE;
              done_o  = 1'b1;
            end else state_d = CAP_SPACE;
          end
        end
        CAP_SPACE: begin
          if (!mark_i && dur_q < DUR_MAX - DUR_W'(1)) begin
            dur_d = dur_inc;
          end else begin
            wr_o     = 1'b1;
            wr_dur_o = mark_i ? dur_q : DUR_MAX;
            slot_d   = slot_q + SLOT_W'(1);
            dur_d    = DUR_W'(1);
            settle_d = '0;
            if (slot_q == LAST) begin
              state_d = CAP_DONE;
              done_o  = 1'b1;
            end else state_d = mark_i ? CAP_MARK : CAP_SETTLE;
          end
        end
        CAP_SETTLE: begin
          if (settle_q >= settle_i) begin
            state_d = CAP_DONE;
            done_o  = 1'b1;
          end else settle_d = settle_q + DUR_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CAP_IDLE;
      dur_q    <= '0;
      slot_q   <= '0;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      dur_q    <= dur_d;
      slot_q   <= slot_d;
      settle_q <= settle_d;
    end
  end

  assign wr_slot_o = slot_q;
  assign slot_o    = slot_q;
endmodule

// File: rtl/ir_cap_bank.sv
module ir_cap_bank
  import ir_cap_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 17,
  parameter int unsigned SLOT_W    = $clog2(4 * NUM_WORDS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      wr_i,
  input  logic [SLOT_W-1:0]         slot_i,
  input  logic [DUR_W-1:0]          dur_i,
  output logic [NUM_WORDS*32-1:0]   words_o
);
  for (genvar s = 0; s < 4 * NUM_WORDS; s++) begin : g_slot
    logic [DUR_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   byte_q <= '0;
      else if (clr_i)                                byte_q <= '0;
      else if (wr_i && slot_i == SLOT_W'(s))         byte_q <= dur_i;
    end
    assign words_o[s*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/ir_pw_capture.sv
module ir_pw_capture
  import ir_cap_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 17,
  parameter int unsigned PERIOD_W   = 16,
  parameter int unsigned RST_PERIOD = 4,
  parameter int unsigned DG_W       = 5,
  parameter int unsigned RST_DG     = 1,
  parameter int unsigned RST_SETTLE = 15,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned SLOTS  = 4 * NUM_WORDS;
  localparam int unsigned SLOT_W = $clog2(SLOTS + 1);
  localparam int unsigned BIDX_W = $clog2(NUM_WORDS);

  logic                run_q, pwd_q, irq_en_q, pend_q;
  logic [DUR_W-1:0]    settle_q;
  logic [PERIOD_W-1:0] period_q;
  logic [DG_W-1:0]     dg_q;
  logic                enabled, tick, mark, restart, ack, done;
  logic                cap_wr;
  logic [SLOT_W-1:0]   cap_slot, slot;
  logic [DUR_W-1:0]    cap_dur;
  logic [NUM_WORDS*32-1:0] bank_w;
  logic [31:0]         bank_arr [NUM_WORDS];
  logic [ADDR_W-1:0]   bank_off;
  logic                bank_hit;
  logic                unused_wdata;

  assign enabled = run_q && pwd_q;
  assign restart = wr_en_i && addr_i == A_RESTART && wdata_i[0];
  assign ack     = wr_en_i && addr_i == A_IRQ_ACK && wdata_i[0];
  assign unused_wdata = ^{wdata_i[31:24], wdata_i[15:14], wdata_i[12:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      pwd_q    <= 1'b0;
      settle_q <= DUR_W'(RST_SETTLE);
      period_q <= PERIOD_W'(RST_PERIOD);
      dg_q     <= DG_W'(RST_DG);
      irq_en_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CTRL: begin
          run_q    <= wdata_i[CTRL_RUN_BIT];
          pwd_q    <= wdata_i[CTRL_PWD_BIT];
          settle_q <= wdata_i[23:16];
        end
        A_PERIOD: period_q <= wdata_i[PERIOD_W-1:0];
        A_FILTER: dg_q     <= wdata_i[8 +: DG_W];
        A_IRQ_EN: irq_en_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pend_q <= 1'b0;
    else if (done) pend_q <= 1'b1;
    else if (ack)  pend_q <= 1'b0;
  end

  assign irq_o = pend_q && irq_en_q;

  ir_cap_tick #(.PERIOD_W(PERIOD_W)) u_tick (
    .clk_i, .rst_ni, .en_i(enabled), .period_i(period_q), .tick_o(tick)
  );

  ir_cap_deglitch #(.DG_W(DG_W), .ACTIVE_LOW(ACTIVE_LOW)) u_dg (
    .clk_i, .rst_ni, .ir_i, .tick_i(tick), .dg_i(dg_q), .mark_o(mark)
  );

  ir_cap_fsm #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_fsm (
    .clk_i, .rst_ni, .tick_i(tick), .mark_i(mark), .restart_i(restart),
    .settle_i(settle_q), .wr_o(cap_wr), .wr_slot_o(cap_slot),
    .wr_dur_o(cap_dur), .slot_o(slot), .done_o(done)
  );

  ir_cap_bank #(.NUM_WORDS(NUM_WORDS), .SLOT_W(SLOT_W)) u_bank (
    .clk_i, .rst_ni, .clr_i(restart), .wr_i(cap_wr), .slot_i(cap_slot),
    .dur_i(cap_dur), .words_o(bank_w)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_view
    assign bank_arr[w] = bank_w[w*32 +: 32];
  end

  assign bank_off = addr_i - A_BANK;
  assign bank_hit = (addr_i >= A_BANK) && (bank_off < ADDR_W'(NUM_WORDS));

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[CTRL_RUN_BIT] = run_q;
      rdata_o[CTRL_PWD_BIT] = pwd_q;
      rdata_o[23:16]        = settle_q;
    end else if (addr_i == A_PERIOD) rdata_o = 32'(period_q);
    else if (addr_i == A_FILTER)     rdata_o[8 +: DG_W] = dg_q;
    else if (addr_i == A_IRQ_EN)     rdata_o[0] = irq_en_q;
    else if (bank_hit)               rdata_o = bank_arr[bank_off[BIDX_W-1:0]];
  end
endmodule

// File: rtl/ir_cap_checker.sv
module ir_cap_checker #(
  parameter int unsigned SLOTS  = 68,
  parameter int unsigned SLOT_W = $clog2(SLOTS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              irq_en,
  input logic              pend,
  input logic              enabled,
  input logic              tick,
  input logic              restart,
  input logic              ack,
  input logic              done,
  input logic [SLOT_W-1:0] slot,
  input logic [31:0]       word0
);
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en);  // R10
  AST_IRQ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !done) |=> !irq_o);  // R10
  AST_DONE_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> pend);  // R7
  AST_NO_TICK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled |-> !tick);  // R2
  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot <= SLOT_W'(SLOTS));  // R8
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart |=> (slot == $past(slot) || slot == $past(slot) + SLOT_W'(1)));  // R4
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == SLOT_W'(SLOTS) && !restart) |=> slot == SLOT_W'(SLOTS));  // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (slot == '0 && word0 == '0));  // R11
endmodule

bind ir_pw_capture ir_cap_checker #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .irq_en(irq_en_q),
  .pend(pend_q), .enabled(enabled), .tick(tick), .restart(restart),
  .ack(ack), .done(done), .slot(slot), .word0(bank_w[31:0])
);

// File: tb/tb_ir_pw_capture.sv
module tb_ir_pw_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          per = 4;
  int          cyc = 0;
  bit          ended = 1'b0;

  always #2.5 clk = ~clk;

  ir_pw_capture dut (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk); #1;
    chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic hold(input logic lvl, input int ticks);
    ir = lvl;
    repeat (ticks * per) @(negedge clk);
  endtask

  task automatic mark(input int t);  hold(1'b0, t); endtask
  task automatic space(input int t); hold(1'b1, t); endtask

  task automatic set_period(input int p);
    per = p;
    wr(6'h01, p);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 6'h00, 32'h000F0000);
    rd_chk("R1 period", 6'h01, 32'd4);
    rd_chk("R1 filter", 6'h02, 32'h00000100);
    rd_chk("R1 irq_en", 6'h03, 32'h0);
    rd_chk("R1 word0", 6'h10, 32'h0);
    rd_chk("R1 word16", 6'h20, 32'h0);
    irq_chk("R1 irq", 1'b0);
  endtask

  task automatic t_disabled();
    wr(6'h03, 32'h1);
    wr(6'h00, 32'h000F0001);
    mark(6); space(4); mark(5); space(300);
    rd_chk("R2 run only word0", 6'h10, 32'h0);
    wr(6'h00, 32'h000F2000);
    mark(6); space(4); mark(5); space(300);
    rd_chk("R2 pwd only word0", 6'h10, 32'h0);
    irq_chk("R2 irq", 1'b0);
  endtask

  task automatic t_basic();
    wr(6'h00, 32'h000F2001);
    wr(6'h05, 32'h1);
    space(10);
    mark(9); space(4); mark(3); space(7); mark(5);
    irq_chk("R7 irq before end", 1'b0);
    space(300);
    rd_chk("R4 R5 word0", 6'h10, 32'h07030409);
    rd_chk("R7 word1", 6'h11, 32'h0000FF05);
    rd_chk("R4 word2", 6'h12, 32'h0);
    irq_chk("R7 irq after end", 1'b1);
    wr(6'h04, 32'h1);
    irq_chk("R10 ack", 1'b0);
  endtask

  task automatic t_period();
    set_period(2);
    wr(6'h05, 32'h1);
    mark(6); space(3); mark(2); space(300);
    rd_chk("R3 period 2", 6'h10, 32'hFF020306);
    wr(6'h04, 32'h1);
    set_period(0);
    per = 1;
    wr(6'h05, 32'h1);
    mark(7); space(2); mark(3); space(300);
    rd_chk("R3 period 0", 6'h10, 32'hFF030207);
    wr(6'h04, 32'h1);
  endtask

  task automatic t_mark_sat();
    set_period(1);
    wr(6'h05, 32'h1);
    mark(300); space(5); mark(2); space(300);
    rd_chk("R6 mark saturates", 6'h10, 32'hFF0205FF);
    wr(6'h04, 32'h1);
  endtask

  task automatic t_glitch();
    set_period(1);
    wr(6'h02, 32'h00000300);
    wr(6'h05, 32'h1);
    mark(10); space(2); mark(10); space(6); mark(4); space(300);
    rd_chk("R9 glitch merged", 6'h10, 32'hFF040616);
    wr(6'h04, 32'h1);
    wr(6'h02, 32'h00000100);
  endtask

  task automatic t_irq_mask();
    set_period(1);
    wr(6'h03, 32'h0);
    wr(6'h05, 32'h1);
    mark(3); space(300);
    irq_chk("R10 masked", 1'b0);
    wr(6'h03, 32'h1);
    irq_chk("R10 unmasked", 1'b1);
    wr(6'h04, 32'h1);
    irq_chk("R10 acked", 1'b0);
  endtask

  task automatic t_full();
    set_period(1);
    wr(6'h05, 32'h1);
    for (int i = 0; i < 34; i++) begin
      mark(2); space(2);
    end
    mark(5); space(5); mark(9); space(300);
    rd_chk("R8 word0", 6'h10, 32'h02020202);
    rd_chk("R8 word8", 6'h18, 32'h02020202);
    rd_chk("R8 word16", 6'h20, 32'h02020202);
    irq_chk("R8 irq", 1'b1);
  endtask

  task automatic t_restart();
    wr(6'h05, 32'h1);
    rd_chk("R11 word0 cleared", 6'h10, 32'h0);
    rd_chk("R11 word16 cleared", 6'h20, 32'h0);
    wr(6'h04, 32'h1);
    space(5);
    mark(4); space(300);
    rd_chk("R11 rearmed", 6'h10, 32'h0000FF04);
    irq_chk("R11 irq", 1'b1);
    wr(6'h04, 32'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_basic();
    t_period();
    t_mark_sat();
    t_glitch();
    t_irq_mask();
    t_full();
    t_restart();
    summary();
  end
endmodule